// File: doc/BRIEF.md
# Signed/Unsigned Decimal Display Driver

This block is the output stage of a small datapath. It keeps one byte, taken from a shared data bus whenever a load strobe is high at a rising clock edge. It shows that byte in decimal on a four-digit seven-segment display. One mode input picks how the stored byte is read. When the input is low, the byte is an unsigned number from 0 to 255. When it is high, the byte is a two's-complement number from -128 to +127, and a minus symbol marks negative values. The mode only changes the view. The stored byte is never altered.

The stored value goes through a combinational binary-to-decimal converter. The converter takes the magnitude of negative signed values, blanks leading zeros and places the sign. A glyph register then holds the result. A scanner lights one digit at a time in round-robin order, with a parameterised refresh divider. A parameter chooses the segment polarity. The digit enables are always active-high.

Top module: `sdd_display`

## Requirements
- R1: While reset is held and after it is released, the held value is 0 and `dig_en` selects digit position 0. After the glyph register has refreshed, the display reads a single "0" in position 0, and positions 1 to 3 are blank.
- R2: When `load_en` is high at a rising clock edge, `held_value` takes the `bus_data` present at that edge.
- R3: With `signed_view` low, the held byte is shown as an unsigned decimal number in the range 0 to 255.
- R4: With `signed_view` high and bit 7 of the held byte set, the display shows the magnitude 256 minus the byte, preceded by a minus symbol, which covers -1 to -128. With bit 7 clear, the byte is shown unsigned with no sign.
- R5: Changing `signed_view` leaves `held_value` unchanged. Returning the mode to its earlier level restores the earlier display.
- R6: Leading zeros are blank. A value of zero shows a single "0" in position 0.
- R7: In signed view, the minus symbol takes the position just above the most significant shown digit, and at most one minus symbol is shown.
- R8: Exactly one bit of `dig_en` is high at any time, and bit 0 drives the rightmost (least significant) digit. The active bit moves from index k to index k+1, wrapping from 3 to 0, once every REFRESH_DIV clock cycles.
- R9: `seg_out` bit 0 to bit 6 drive segments a to g. With SEG_ACTIVE_LOW = 0, a lit segment is 1, and the digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex). Minus is 40 and blank is 00. With SEG_ACTIVE_LOW = 1, every bit is the inverse.
- R10: While `load_en` is low, changes on `bus_data` do not affect `held_value` or the display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_data | input | DATA_W | Shared data bus |
| load_en | input | 1 | Output-register load strobe |
| signed_view | input | 1 | 0 selects the unsigned view, 1 selects the two's-complement view |
| held_value | output | DATA_W | Byte currently held in the output register |
| seg_out | output | 7 | Segment drive for the digit now selected, bits a to g |
| dig_en | output | NUM_DIGITS | One-hot digit enable, active-high, bit 0 is the rightmost digit |

## Verification
The bytes in the table are chosen to sit on the edges of the conversion.
- **Digit-count edges:** 0, 9, 10, 99, 100, 127 and 255 show where the digit count changes and where blanking must stop.
- **Sign boundaries:** 128 and 255 appear in both views. This separates -128 and -1 from their unsigned readings and tests the magnitude step at its extremes.
- **Sign placement:** -10, -56 and -100 put the minus in positions 2, 2 and 3, so a sign placed at a fixed position would fail.

Two directed tests cover the quiet paths. Bus traffic without a load, and mode toggles without a load, must leave the held byte unchanged. The scan order, the run length of each digit and the inverted-polarity twin instance are checked on every sampled cycle.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

   // Glyph codes carried between conversion and scanning
   typedef enum logic [3:0] {
      GL_D0    = 4'd0,
      GL_D1    = 4'd1,
      GL_D2    = 4'd2,
      GL_D3    = 4'd3,
      GL_D4    = 4'd4,
      GL_D5    = 4'd5,
      GL_D6    = 4'd6,
      GL_D7    = 4'd7,
      GL_D8    = 4'd8,
      GL_D9    = 4'd9,
      GL_BLANK = 4'd10,
      GL_MINUS = 4'd11
   } glyph_t;

   // Number of decimal digits needed for an unsigned value of the given width
   function automatic int dec_digits(input int bits);
      longint unsigned m;
      int n;
      m = (64'd1 << bits) - 64'd1;
      n = 1;
      for (int i = 0; i < 20; i++) begin
         if (m >= 64'd10) begin
            m = m / 64'd10;
            n++;
         end
      end
      return n;
   endfunction

   // Active-high segment pattern, bit0 = a ... bit6 = g
   function automatic logic [6:0] glyph_segs(input glyph_t g);
      logic [6:0] s;
      case (g)
         GL_D0:    s = 7'h3F;
         GL_D1:    s = 7'h06;
         GL_D2:    s = 7'h5B;
         GL_D3:    s = 7'h4F;
         GL_D4:    s = 7'h66;
         GL_D5:    s = 7'h6D;
         GL_D6:    s = 7'h7D;
         GL_D7:    s = 7'h07;
         GL_D8:    s = 7'h7F;
         GL_D9:    s = 7'h6F;
         GL_MINUS: s = 7'h40;
         default:  s = 7'h00;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/sdd_hold_reg.sv
module sdd_hold_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)       q <= '0;
      else if (load_en) q <= d;
   end

   AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (q == $past(d))) else $error("load not captured"); // R2

   AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable(q)) else $error("value moved without load"); // R10

endmodule

// File: rtl/sdd_b2d.sv
module sdd_b2d
   import sdd_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NUM_DIGITS = 4
) (
   input  logic                      [DATA_W-1:0]     value,
   input  logic                                       signed_view,
   output glyph_t                    [NUM_DIGITS-1:0] glyphs
);

   localparam int BCD_W = 4 * NUM_DIGITS;

   logic              negative;
   logic [DATA_W-1:0] mag;
   logic [BCD_W-1:0]  bcd;

   // Sign handling: the same byte, reinterpreted only when signed view is set
   assign negative = signed_view & value[DATA_W-1];
   assign mag      = negative ? (~value + DATA_W'(1)) : value;

   // Shift-and-add-three binary to BCD
   always_comb begin
      bcd = '0;
      for (int b = DATA_W - 1; b >= 0; b--) begin
         for (int d = 0; d < NUM_DIGITS; d++) begin
            if (bcd[d*4 +: 4] >= 4'd5) bcd[d*4 +: 4] = bcd[d*4 +: 4] + 4'd3;
         end
         bcd = {bcd[BCD_W-2:0], mag[b]};
      end
   end

   // Leading-zero blanking and sign placement
   always_comb begin
      int msd;
      msd = 0;
      for (int d = 0; d < NUM_DIGITS; d++) begin
         if (bcd[d*4 +: 4] != 4'd0) msd = d;
      end
      for (int d = 0; d < NUM_DIGITS; d++) begin
         if (d <= msd)                   glyphs[d] = glyph_t'(bcd[d*4 +: 4]);
         else if (negative && d == msd + 1) glyphs[d] = GL_MINUS;
         else                            glyphs[d] = GL_BLANK;
      end
   end

endmodule

// File: rtl/sdd_scan.sv
module sdd_scan
   import sdd_pkg::*;
#(
   parameter int NUM_DIGITS     = 4,
   parameter int REFRESH_DIV    = 1024,
   parameter bit SEG_ACTIVE_LOW = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  glyph_t [NUM_DIGITS-1:0]     glyphs,
   output logic   [6:0]                seg_out,
   output logic   [NUM_DIGITS-1:0]     dig_en
);

   localparam int DIV_W = (REFRESH_DIV > 1) ? $clog2(REFRESH_DIV) : 1;
   localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(REFRESH_DIV - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_DIGITS - 1);

   glyph_t [NUM_DIGITS-1:0] glyph_q;
   logic   [DIV_W-1:0]      div_cnt;
   logic   [IDX_W-1:0]      scan_idx;
   logic                    step;
   logic   [6:0]            seg_hi;

   assign step = (div_cnt == DIV_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_DIGITS; i++) glyph_q[i] <= GL_BLANK;
      end else begin
         glyph_q <= glyphs;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_cnt  <= '0;
         scan_idx <= '0;
      end else if (step) begin
         div_cnt  <= '0;
         scan_idx <= (scan_idx == IDX_LAST) ? '0 : scan_idx + IDX_W'(1);
      end else begin
         div_cnt  <= div_cnt + DIV_W'(1);
      end
   end

   for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_en
      assign dig_en[g] = (scan_idx == IDX_W'(g));
   end

   assign seg_hi = glyph_segs(glyph_q[scan_idx]);

   if (SEG_ACTIVE_LOW) begin : g_pol_low
      assign seg_out = ~seg_hi;
   end else begin : g_pol_high
      assign seg_out = seg_hi;
   end

   AST_ONE_DIGIT_ON: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dig_en) == 1) else $error("digit enable not one-hot"); // R8

   AST_SCAN_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(dig_en)) else $error("digit moved early"); // R8

   AST_SCAN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && dig_en[NUM_DIGITS-1]) |=> dig_en[0]) else $error("scan did not wrap"); // R8

endmodule

// File: rtl/sdd_display.sv
module sdd_display
   import sdd_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int NUM_DIGITS     = 4,
   parameter int REFRESH_DIV    = 1024,
   parameter bit SEG_ACTIVE_LOW = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DATA_W-1:0]     bus_data,
   input  logic                  load_en,
   input  logic                  signed_view,
   output logic [DATA_W-1:0]     held_value,
   output logic [6:0]            seg_out,
   output logic [NUM_DIGITS-1:0] dig_en
);

   localparam int NEED_DIGITS = dec_digits(DATA_W) + 1;

   initial begin
      assert (NUM_DIGITS >= NEED_DIGITS) else $error("too few digits for DATA_W");
      assert (REFRESH_DIV >= 1) else $error("REFRESH_DIV must be positive");
      assert (DATA_W >= 2) else $error("DATA_W too small");
   end

   glyph_t [NUM_DIGITS-1:0] glyphs;
   logic   [NUM_DIGITS-1:0] minus_hit;

   sdd_hold_reg #(.W(DATA_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (load_en),
      .d       (bus_data),
      .q       (held_value)
   );

   sdd_b2d #(.DATA_W(DATA_W), .NUM_DIGITS(NUM_DIGITS)) u_b2d (
      .value       (held_value),
      .signed_view (signed_view),
      .glyphs      (glyphs)
   );

   sdd_scan #(
      .NUM_DIGITS     (NUM_DIGITS),
      .REFRESH_DIV    (REFRESH_DIV),
      .SEG_ACTIVE_LOW (SEG_ACTIVE_LOW)
   ) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .glyphs  (glyphs),
      .seg_out (seg_out),
      .dig_en  (dig_en)
   );

   for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_minus
      assign minus_hit[g] = (glyphs[g] == GL_MINUS);
   end

   AST_NO_SIGN_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      !signed_view |-> (minus_hit == '0)) else $error("minus in unsigned view"); // R3

   AST_SIGN_WHEN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      (signed_view && held_value[DATA_W-1]) |-> (minus_hit != '0)) else $error("missing minus"); // R4

   AST_SINGLE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(minus_hit) <= 1) else $error("more than one minus"); // R7

   AST_UNITS_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
      glyphs[0] != GL_BLANK && glyphs[0] != GL_MINUS) else $error("units digit blank"); // R6

endmodule

// File: tb/sim_sdd_display.sv
`timescale 1ns/1ps
module sim_sdd_display;

   localparam int ND  = 4;
   localparam int DIV = 4;
   localparam int NV  = 14;

   // {signed_view, value}
   localparam logic [8:0] VEC [NV] = '{
      9'h000, 9'h100, 9'h009, 9'h00A, 9'h063, 9'h064, 9'h07F,
      9'h080, 9'h180, 9'h0FF, 9'h1FF, 9'h1C8, 9'h19C, 9'h1F6
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_data = 8'h00;
   logic       load_en = 1'b0;
   logic       signed_view = 1'b0;
   logic [7:0] held_value, held_value1;
   logic [6:0] seg0, seg1;
   logic [ND-1:0] dig_en, dig_en1;

   int checks = 0;
   int errors = 0;
   logic [6:0] cap [ND];
   int pol_bad = 0;

   always #4 clk = ~clk;

   sdd_display #(.DATA_W(8), .NUM_DIGITS(ND), .REFRESH_DIV(DIV), .SEG_ACTIVE_LOW(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .load_en(load_en),
      .signed_view(signed_view), .held_value(held_value), .seg_out(seg0), .dig_en(dig_en)
   );

   sdd_display #(.DATA_W(8), .NUM_DIGITS(ND), .REFRESH_DIV(DIV), .SEG_ACTIVE_LOW(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .load_en(load_en),
      .signed_view(signed_view), .held_value(held_value1), .seg_out(seg1), .dig_en(dig_en1)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   function automatic logic [6:0] dcode(input int d);
      case (d)
         0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
         4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
         8: return 7'h7F; default: return 7'h6F;
      endcase
   endfunction

   function automatic logic [27:0] expect_disp(input logic [7:0] v, input logic m);
      int n, mag, nd, t;
      logic neg;
      logic [27:0] r;
      n   = (m && v[7]) ? int'(v) - 256 : int'(v);
      neg = (n < 0);
      mag = neg ? -n : n;
      nd  = (mag >= 100) ? 3 : (mag >= 10) ? 2 : 1;
      t   = mag;
      r   = '0;
      for (int p = 0; p < ND; p++) begin
         if (p < nd)               r[p*7 +: 7] = dcode(t % 10);
         else if (neg && p == nd)  r[p*7 +: 7] = 7'h40;
         else                      r[p*7 +: 7] = 7'h00;
         t = t / 10;
      end
      return r;
   endfunction

   // Capture one pattern per digit position over two full scans
   task automatic sweep(output logic [27:0] shown);
      repeat (3) @(negedge clk);
      for (int c = 0; c < 2 * ND * DIV; c++) begin
         @(negedge clk);
         for (int k = 0; k < ND; k++) if (dig_en[k]) cap[k] = seg0;
         if (seg1 !== ~seg0) pol_bad++;
      end
      shown = {cap[3], cap[2], cap[1], cap[0]};
   endtask

   task automatic load(input logic [7:0] v);
      @(negedge clk);
      bus_data = v;
      load_en  = 1'b1;
      @(negedge clk);
      load_en  = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [27:0] shown;
      logic [7:0]  v;
      logic        m;
      int run, prev, idx, scan_bad;
      bit started;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 held during reset", 32'(held_value), 32'h0);
      chk("R1 digit select during reset", 32'(dig_en), 32'h1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 held after reset", 32'(held_value), 32'h0);
      sweep(shown);
      chk("R1 R6 zero display after reset", 32'(shown), 32'(expect_disp(8'h00, 1'b0)));

      // Table walk: R2 R3 R4 R6 R7 R9
      for (int i = 0; i < NV; i++) begin
         v = VEC[i][7:0];
         m = VEC[i][8];
         signed_view = m;
         load(v);
         chk("R2 load capture", 32'(held_value), 32'(v));
         sweep(shown);
         if (m && v[7])  chk("R4 R7 signed negative view", 32'(shown), 32'(expect_disp(v, m)));
         else if (m)     chk("R4 R6 signed positive view", 32'(shown), 32'(expect_disp(v, m)));
         else            chk("R3 R6 unsigned view", 32'(shown), 32'(expect_disp(v, m)));
      end

      // R10: bus activity without load has no effect
      signed_view = 1'b0;
      load(8'd77);
      @(negedge clk);
      bus_data = 8'd200;
      repeat (5) @(negedge clk);
      bus_data = 8'hAA;
      chk("R10 held unchanged", 32'(held_value), 32'd77);
      sweep(shown);
      chk("R10 display unchanged", 32'(shown), 32'(expect_disp(8'd77, 1'b0)));

      // R5: mode toggles leave stored byte untouched
      load(8'hF6);
      signed_view = 1'b1;
      sweep(shown);
      chk("R5 signed view of F6", 32'(shown), 32'(expect_disp(8'hF6, 1'b1)));
      chk("R5 held after signed view", 32'(held_value), 32'hF6);
      signed_view = 1'b0;
      sweep(shown);
      chk("R5 unsigned view restored", 32'(shown), 32'(expect_disp(8'hF6, 1'b0)));
      chk("R5 held after toggle back", 32'(held_value), 32'hF6);

      // R8: scan order and dwell
      scan_bad = 0;
      started  = 1'b0;
      run      = 0;
      prev     = -1;
      for (int c = 0; c < 5 * ND * DIV; c++) begin
         @(negedge clk);
         idx = -1;
         if ($countones(dig_en) != 1) scan_bad++;
         for (int k = 0; k < ND; k++) if (dig_en[k]) idx = k;
         if (prev < 0) begin
            prev = idx;
         end else if (idx != prev) begin
            if (idx != (prev + 1) % ND) scan_bad++;
            if (started && run != DIV) scan_bad++;
            started = 1'b1;
            run     = 1;
            prev    = idx;
         end else begin
            run++;
         end
      end
      chk("R8 scan order and dwell", 32'(scan_bad), 32'h0);

      // R9: inverted polarity twin
      chk("R9 active-low segments are inverse", 32'(pol_bad), 32'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule